// File: doc/BRIEF.md
# Bit Test and Clear Unit

This unit carries out the single-bit test and single-bit clear instructions of a processor with 16-bit opcode words. When `start` is high while the unit is idle, it decodes the opcode on `opcode`. It accepts four forms: a test or a clear, each with the bit number either held in a data register or carried in an extension word. The operand is either a 32-bit data register or one byte in memory. The register file is read through two combinational select/data port pairs. The extension word is sampled during a dedicated fetch cycle. The memory address comes from outside the unit, already calculated.

Each instruction ends with a one-cycle `done` pulse. In that same cycle the unit presents the zero flag, the result operand and the number of cycles it was busy. A register clear also raises a write-enable for the register file in that cycle. Memory operands use a request/acknowledge byte bus. The unit waits in the current bus state for as many cycles as the acknowledge takes.

The controller is a state machine with eight states:

| State | What happens in it |
|-------|--------------------|
| `ST_IDLE` | Waits for `start`. |
| `ST_EXT` | Extension-word fetch slot. |
| `ST_GAP` | Idle cycle taken only in predecrement mode. |
| `ST_RD` | Byte read request. |
| `ST_PF` | Prefetch slot. |
| `ST_WR` | Byte write request. |
| `ST_EXEC` | Timed register operation. |
| `ST_DONE` | Completion cycle. |

Its transitions are:

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_EXT` | Legal immediate-form opcode. |
| `ST_IDLE` | `ST_EXEC` | Legal register-form opcode with a register operand. |
| `ST_IDLE` | `ST_GAP` | Legal register-form opcode in predecrement mode. |
| `ST_IDLE` | `ST_RD` | Any other legal register-form opcode with a memory operand. |
| `ST_EXT` | `ST_EXEC`, `ST_GAP` or `ST_RD` | Chosen by the same operand-kind and predecrement rules as from `ST_IDLE`. |
| `ST_GAP` | `ST_RD` | Always. |
| `ST_RD` | `ST_PF` | On acknowledge. |
| `ST_PF` | `ST_WR` | For a clear. |
| `ST_PF` | `ST_DONE` | For a test. |
| `ST_WR` | `ST_DONE` | On acknowledge. |
| `ST_EXEC` | `ST_DONE` | When the countdown reaches its last cycle. |
| `ST_DONE` | `ST_IDLE` | Always. |

Top module: `btc_unit`

## Requirements
- R1: A register-form opcode is one where (opcode & 0xF1C0) is 0x0100 (test) or 0x0180 (clear). The bit number is read from the data register selected by opcode[11:9], which is presented on `src_sel`.
- R2: An immediate-form opcode is one where (opcode & 0xFFC0) is 0x0800 (test) or 0x0880 (clear). The unit spends exactly one cycle in the extension fetch slot (`ext_fetch` high). This is the first busy cycle, and the unit takes the bit number from `ext_word` in it.
- R3: The addressing mode is opcode[5:3] and the register is opcode[2:0]. With mode 000 the operand is data register opcode[2:0], 32 bits wide, and the bit number is taken modulo 32. With any other legal mode the operand is one memory byte and the bit number is taken modulo 8.
- R4: `zero_flag` is 1 when the selected bit of the original operand is 0, and 0 when that bit is 1. It is computed before any change to the operand.
- R5: A clear returns the operand with only the selected bit forced to 0, and writes it back. For a register operand, `rf_we` is high with `rf_wsel` = opcode[2:0]. For a memory operand, the byte is written. A test returns the operand unchanged and performs no write of either kind.
- R6: A register-operand instruction is busy for 2 cycles for a test, 4 cycles for a clear of bit (n mod 32) < 16, and 6 cycles for a clear of bit (n mod 32) >= 16. The immediate form adds one cycle.
- R7: A memory-operand instruction performs a byte read, then exactly one cycle with no request (the prefetch slot), then, only for a clear, a byte write of the modified byte to the same address.
- R8: In predecrement mode (opcode[5:3] = 100) the unit spends one cycle without a bus request before the read request.
- R9: An opcode that matches none of the four forms raises `illegal` in the same cycle and starts nothing. The same applies to a legal form with mode 001, or with mode 111 and register 4 or above: no busy cycle, no bus request, no `done`.
- R10: `mem_req`, `mem_we` and `mem_addr` stay unchanged while a request waits for `mem_ack`. Each wait cycle adds one busy cycle.
- R11: `done` is high for exactly one cycle per instruction. `zero_flag`, `result` and `cycles` are valid in that cycle, and `cycles` equals the number of cycles the unit was busy, including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| opcode | input | 16 | Opcode word, valid with `start` |
| mem_addr_in | input | ADDR_W | Calculated operand address, valid with `start` |
| src_sel | output | 3 | Register index of the bit number (opcode[11:9]) |
| src_data | input | DATA_W | Contents of register `src_sel` |
| dst_sel | output | 3 | Register index of the operand (opcode[2:0]) |
| dst_data | input | DATA_W | Contents of register `dst_sel` |
| ext_fetch | output | 1 | Extension-word fetch slot is active |
| ext_word | input | 16 | Extension word, sampled while `ext_fetch` is high |
| mem_req | output | 1 | Byte bus request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes in this cycle |
| rf_we | output | 1 | Register write-back strobe (in the `done` cycle) |
| rf_wsel | output | 3 | Register index for the write-back |
| busy | output | 1 | Unit is not idle |
| done | output | 1 | One-cycle completion pulse |
| zero_flag | output | 1 | Inverse of the selected original bit |
| result | output | DATA_W | Result operand (memory byte zero-extended) |
| cycles | output | CYC_W | Busy cycle count of the instruction |
| illegal | output | 1 | Rejected opcode |

## Verification
The hardest case to reach is the predecrement clear with an immediate bit number and a slow acknowledge. In that one instruction the extension slot, the idle gap, a stalled read, the prefetch slot and a stalled write all follow each other. The order of the bus phases and the final cycle count can only be seen if every one of them happens. The bench reaches it by building that exact opcode and setting a per-instruction acknowledge delay in its memory responder. It then predicts, for every cycle, whether a read or write request should be present. Bit numbers are chosen above 31 and above 7 to exercise the modulo, and near 16 to exercise the upper-half timing.

// File: rtl/btc_pkg.sv
`timescale 1ns/1ps
package btc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_GAP,
        ST_RD,
        ST_PF,
        ST_WR,
        ST_EXEC,
        ST_DONE
    } btc_state_e;

    // Decoded view of one opcode word
    typedef struct packed {
        logic       legal;
        logic       imm;      // bit number from extension word
        logic       clr;      // clear, else test
        logic       reg_dst;  // operand is a data register
        logic       predec;   // predecrement addressing
        logic [2:0] dsel;     // operand register index
    } btc_dec_t;

    localparam logic [2:0] EA_DREG   = 3'b000;
    localparam logic [2:0] EA_AREG   = 3'b001;
    localparam logic [2:0] EA_PREDEC = 3'b100;
    localparam logic [2:0] EA_EXT    = 3'b111;

    localparam logic [15:0] RF_MASK  = 16'hF1C0;
    localparam logic [15:0] RF_TEST  = 16'h0100;
    localparam logic [15:0] RF_CLEAR = 16'h0180;
    localparam logic [15:0] IM_MASK  = 16'hFFC0;
    localparam logic [15:0] IM_TEST  = 16'h0800;
    localparam logic [15:0] IM_CLEAR = 16'h0880;

endpackage

// File: rtl/btc_decode.sv
`timescale 1ns/1ps
module btc_decode
    import btc_pkg::*;
(
    input  logic [15:0] op,
    output btc_dec_t    dec
);
    logic       reg_t, reg_c, imm_t, imm_c;
    logic [2:0] mode;
    logic [2:0] rnum;
    logic       ea_ok;

    always_comb begin
        reg_t = (op & RF_MASK) == RF_TEST;
        reg_c = (op & RF_MASK) == RF_CLEAR;
        imm_t = (op & IM_MASK) == IM_TEST;
        imm_c = (op & IM_MASK) == IM_CLEAR;
        mode  = op[5:3];
        rnum  = op[2:0];
        ea_ok = (mode != EA_AREG) && !((mode == EA_EXT) && rnum[2]);

        dec.legal   = (reg_t | reg_c | imm_t | imm_c) && ea_ok;
        dec.imm     = imm_t | imm_c;
        dec.clr     = reg_c | imm_c;
        dec.reg_dst = (mode == EA_DREG);
        dec.predec  = (mode == EA_PREDEC);
        dec.dsel    = rnum;
    end
endmodule

// File: rtl/btc_bitop.sv
`timescale 1ns/1ps
module btc_bitop #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] bitval,
    input  logic              wide,
    output logic              zero,
    output logic [DATA_W-1:0] cleared
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mask;

    always_comb begin
        if (wide) idx = IDX_W'(bitval % DATA_W);
        else      idx = IDX_W'(bitval % BYTE_W);
        mask    = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
        zero    = ~|(operand & mask);
        cleared = operand & ~mask;
    end
endmodule

// File: rtl/btc_exec_len.sv
`timescale 1ns/1ps
module btc_exec_len #(
    parameter int DATA_W     = 32,
    parameter int CYC_W      = 8,
    parameter int TEST_LEN   = 2,
    parameter int CLR_LO_LEN = 4,
    parameter int CLR_HI_LEN = 6
) (
    input  logic              clr,
    input  logic [DATA_W-1:0] bitval,
    output logic [CYC_W-1:0]  len
);
    localparam int HALF = DATA_W / 2;

    logic upper;

    always_comb begin
        upper = (bitval % DATA_W) >= HALF;
        if (!clr)      len = CYC_W'(TEST_LEN);
        else if (upper) len = CYC_W'(CLR_HI_LEN);
        else           len = CYC_W'(CLR_LO_LEN);
    end
endmodule

// File: rtl/btc_unit.sv
`timescale 1ns/1ps
module btc_unit
    import btc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 24,
    parameter int CYC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       opcode,
    input  logic [ADDR_W-1:0] mem_addr_in,
    output logic [2:0]        src_sel,
    input  logic [DATA_W-1:0] src_data,
    output logic [2:0]        dst_sel,
    input  logic [DATA_W-1:0] dst_data,
    output logic              ext_fetch,
    input  logic [15:0]       ext_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              rf_we,
    output logic [2:0]        rf_wsel,
    output logic              busy,
    output logic              done,
    output logic              zero_flag,
    output logic [DATA_W-1:0] result,
    output logic [CYC_W-1:0]  cycles,
    output logic              illegal
);
    localparam int EXT_PAD = DATA_W - 16;

    btc_state_e st_q, st_d;
    btc_dec_t   dec_in, dec_q, dec_cur;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] bit_q;
    logic [DATA_W-1:0] opnd_q;
    logic [CYC_W-1:0]  cnt_q;
    logic [CYC_W-1:0]  left_q;

    logic              accept;
    logic [DATA_W-1:0] bit_now;
    logic [CYC_W-1:0]  len_now;
    logic              op_zero;
    logic [DATA_W-1:0] op_cleared;

    // ---------------- sub-blocks ----------------
    btc_decode u_dec (
        .op  (opcode),
        .dec (dec_in)
    );

    btc_exec_len #(
        .DATA_W (DATA_W),
        .CYC_W  (CYC_W)
    ) u_len (
        .clr    (dec_cur.clr),
        .bitval (bit_now),
        .len    (len_now)
    );

    btc_bitop #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_bit (
        .operand (opnd_q),
        .bitval  (bit_q),
        .wide    (dec_q.reg_dst),
        .zero    (op_zero),
        .cleared (op_cleared)
    );

    // ---------------- glue ----------------
    always_comb begin
        src_sel = opcode[11:9];
        dst_sel = opcode[2:0];
        accept  = (st_q == ST_IDLE) && start && dec_in.legal;
        illegal = (st_q == ST_IDLE) && start && !dec_in.legal;
        dec_cur = (st_q == ST_IDLE) ? dec_in : dec_q;
        bit_now = (st_q == ST_EXT) ? {{EXT_PAD{1'b0}}, ext_word} : src_data;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_in.imm)          st_d = ST_EXT;
                    else if (dec_in.reg_dst) st_d = ST_EXEC;
                    else if (dec_in.predec)  st_d = ST_GAP;
                    else                     st_d = ST_RD;
                end
            end
            ST_EXT: begin
                if (dec_q.reg_dst)     st_d = ST_EXEC;
                else if (dec_q.predec) st_d = ST_GAP;
                else                   st_d = ST_RD;
            end
            ST_GAP:  st_d = ST_RD;
            ST_RD:   if (mem_ack) st_d = ST_PF;
            ST_PF:   st_d = dec_q.clr ? ST_WR : ST_DONE;
            ST_WR:   if (mem_ack) st_d = ST_DONE;
            ST_EXEC: if (left_q <= CYC_W'(1)) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q  <= '0;
            addr_q <= '0;
            bit_q  <= '0;
            opnd_q <= '0;
            cnt_q  <= '0;
            left_q <= '0;
        end else begin
            if (accept) begin
                dec_q  <= dec_in;
                addr_q <= mem_addr_in;
                bit_q  <= src_data;
                opnd_q <= dec_in.reg_dst ? dst_data : '0;
                cnt_q  <= CYC_W'(1);
                left_q <= len_now - CYC_W'(1);
            end else if (st_q != ST_IDLE && st_q != ST_DONE) begin
                cnt_q <= cnt_q + CYC_W'(1);
            end

            if (st_q == ST_EXT) begin
                bit_q  <= bit_now;
                left_q <= len_now - CYC_W'(1);
            end
            if (st_q == ST_EXEC) begin
                left_q <= left_q - CYC_W'(1);
            end
            if (st_q == ST_RD && mem_ack) begin
                opnd_q <= {{(DATA_W-BYTE_W){1'b0}}, mem_rdata};
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = 1'b0;
        ext_fetch = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        rf_we     = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_EXT:  begin busy = 1'b1; ext_fetch = 1'b1; end
            ST_GAP:  busy = 1'b1;
            ST_RD:   begin busy = 1'b1; mem_req = 1'b1; end
            ST_PF:   busy = 1'b1;
            ST_WR:   begin busy = 1'b1; mem_req = 1'b1; mem_we = 1'b1; end
            ST_EXEC: busy = 1'b1;
            ST_DONE: begin
                busy  = 1'b1;
                done  = 1'b1;
                rf_we = dec_q.reg_dst && dec_q.clr;
            end
            default: ;
        endcase
        mem_addr  = addr_q;
        mem_wdata = op_cleared[BYTE_W-1:0];
        rf_wsel   = dec_q.dsel;
        zero_flag = done && op_zero;
        result    = done ? (dec_q.clr ? op_cleared : opnd_q) : '0;
        cycles    = done ? cnt_q : '0;
    end

endmodule

// File: rtl/btc_unit_chk.sv
`timescale 1ns/1ps
module btc_unit_chk
    import btc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CYC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input btc_state_e        st,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              rf_we,
    input logic [CYC_W-1:0]  cycles
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!busy && !mem_req && !done));

    assert_write_after_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> ($past(busy) && !$past(mem_req)));

    assert_gap_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |=> (mem_req && !mem_we));

    assert_clear_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rf_we) |-> (cycles >= CYC_W'(4) && cycles <= CYC_W'(7)));

    assert_test_no_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done);
endmodule

bind btc_unit btc_unit_chk #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_q),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .rf_we    (rf_we),
    .cycles   (cycles)
);

// File: tb/btc_unit_tb_top.sv
`timescale 1ns/1ps
module btc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [23:0] mem_addr_in = '0;
    logic [2:0]  src_sel, dst_sel, rf_wsel;
    logic [31:0] src_data, dst_data, result;
    logic        ext_fetch, mem_req, mem_we, rf_we, busy, done, zero_flag, illegal;
    logic [15:0] ext_word = '0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  cycles;

    logic [31:0] rf [8];
    logic [7:0]  mem_b [256];
    int          dly = 0;
    int          wait_cnt = 0;
    int          wr_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          fin = 1'b0;

    always #4 clk = ~clk;

    assign src_data = rf[src_sel];
    assign dst_data = rf[dst_sel];

    btc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .mem_addr_in(mem_addr_in), .src_sel(src_sel), .src_data(src_data),
        .dst_sel(dst_sel), .dst_data(dst_data), .ext_fetch(ext_fetch),
        .ext_word(ext_word), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .rf_we(rf_we), .rf_wsel(rf_wsel), .busy(busy),
        .done(done), .zero_flag(zero_flag), .result(result), .cycles(cycles),
        .illegal(illegal)
    );

    // Byte memory responder with a programmable acknowledge delay
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt == dly) begin
                mem_ack = 1'b1;
                wait_cnt = 0;
                if (mem_we) begin
                    mem_b[mem_addr[7:0]] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem_b[mem_addr[7:0]];
                end
            end else begin
                mem_ack = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: predicts every cycle of one instruction
    task automatic run(input logic [15:0] op, input logic [23:0] addr,
                       input logic [15:0] ext, input int d);
        bit     imm    = (op[15:8] == 8'h08);
        bit     clr    = op[7];
        bit     regdst = (op[5:3] == 3'b000);
        bit     pre    = (op[5:3] == 3'b100);
        int     bitn   = imm ? int'(ext) : int'(rf[op[11:9]] & 32'hFFFF);
        int     idx    = regdst ? bitn % 32 : bitn % 8;
        longint orig   = regdst ? longint'(rf[op[2:0]]) : longint'(mem_b[addr[7:0]]);
        longint mask   = longint'(1) << idx;
        longint expres = clr ? (orig & ~mask) : orig;
        bit     expz   = ((orig & mask) == 0);
        int     r0     = 1 + int'(imm) + int'(pre);
        int     expn;
        int     w0     = 0;
        int     wr0    = wr_cnt;
        string  tq     = regdst ? "R6" : "R7";
        if (regdst)
            expn = int'(imm) + (clr ? ((idx >= 16) ? 6 : 4) : 2);
        else begin
            w0   = r0 + d + 2;
            expn = clr ? (w0 + d + 1) : (r0 + d + 2);
        end
        dly = d;
        @(negedge clk);
        opcode = op; mem_addr_in = addr; ext_word = ext; start = 1'b1;
        for (int n = 1; n <= expn + 20; n++) begin
            bit er, ew;
            @(negedge clk);
            start = 1'b0;
            #1;
            er = !regdst && ((n >= r0 && n <= r0 + d) ||
                             (clr && n >= w0 && n <= w0 + d));
            ew = !regdst && clr && n >= w0 && n <= w0 + d;
            chk(mem_req == er, pre ? "R8" : "R10", "mem_req per cycle", mem_req, er);
            chk(mem_we == ew, "R5", "mem_we per cycle", mem_we, ew);
            chk(done == (n == expn), tq, "done per cycle", done, (n == expn));
            if (n == 1) chk(ext_fetch == imm, "R2", "ext slot", ext_fetch, imm);
            if (er) chk(mem_addr == addr, "R7", "address", mem_addr, addr);
            if (n == expn) begin
                chk(zero_flag == expz, "R4", "zero flag", zero_flag, expz);
                chk(longint'(result) == expres, "R3", "result", result, expres);
                chk(int'(cycles) == expn, "R11", "cycle count", cycles, expn);
                chk(rf_we == (regdst && clr), "R5", "rf_we", rf_we, (regdst && clr));
                if (rf_we) chk(rf_wsel == op[2:0], "R5", "rf_wsel", rf_wsel, op[2:0]);
            end
            if (n == expn + 1) begin
                chk(done == 1'b0, "R11", "done pulse width", done, 0);
                break;
            end
        end
        if (!regdst) begin
            chk(longint'(mem_b[addr[7:0]]) == expres, "R5", "memory byte", mem_b[addr[7:0]], expres);
            chk(wr_cnt - wr0 == int'(clr), "R7", "write count", wr_cnt - wr0, clr);
        end
    endtask

    task automatic bad(input logic [15:0] op);
        @(negedge clk);
        opcode = op; start = 1'b1;
        #1;
        chk(illegal == 1'b1, "R9", "illegal raised", illegal, 1);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(!busy && !mem_req && !done && !illegal, "R9", "nothing started",
            {busy, mem_req, done, illegal}, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = '0;
        for (int i = 0; i < 256; i++) mem_b[i] = 8'(i * 7);
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !mem_req && !ext_fetch, "R11", "reset outputs",
            {busy, done, mem_req, ext_fetch}, 0);
        rst_n = 1'b1;

        // R1: register-form test, 32-bit operand
        rf[1] = 5; rf[2] = 32'h0000_0020;
        run(16'h0100 | (16'd1 << 9) | 16'd2, 24'h0, 16'h0, 0);
        // R6: register clear, lower half, 4 cycles
        rf[3] = 3; rf[4] = 32'hFFFF_FFFF;
        run(16'h0180 | (16'd3 << 9) | 16'd4, 24'h0, 16'h0, 0);
        // R3 + R6: bit 52 -> 20, upper half, 6 cycles
        rf[5] = 52; rf[6] = 32'h0010_0000;
        run(16'h0180 | (16'd5 << 9) | 16'd6, 24'h0, 16'h0, 0);
        // R2: immediate clear of bit 31, 7 cycles
        rf[7] = 32'h8000_0001;
        run(16'h0887, 24'h0, 16'd31, 0);
        // R4: immediate test of a zero bit
        rf[0] = 32'h2;
        run(16'h0800, 24'h0, 16'd0, 0);
        // R6: test of an upper-half bit stays at 2 cycles
        rf[1] = 30; rf[2] = 32'h4000_0000;
        run(16'h0100 | (16'd1 << 9) | 16'd2, 24'h0, 16'h0, 0);
        // R3 + R7: memory test, bit 11 -> 3
        rf[1] = 11; mem_b[8'h40] = 8'h08;
        run(16'h0100 | (16'd1 << 9) | (16'd2 << 3), 24'h000040, 16'h0, 0);
        // R7 + R10: memory clear with post-increment, slow acknowledge
        rf[1] = 6; mem_b[8'h41] = 8'hFF;
        run(16'h0180 | (16'd1 << 9) | (16'd3 << 3), 24'h000041, 16'h0, 2);
        // R8: immediate predecrement clear, bit 0x102 -> 2
        mem_b[8'h42] = 8'h04;
        run(16'h0880 | (16'd4 << 3) | 16'd1, 24'h000042, 16'h0102, 1);
        // R5: immediate displacement test, no write
        mem_b[8'h43] = 8'h00;
        run(16'h0800 | (16'd5 << 3), 24'h000043, 16'd7, 3);
        // R4 + R5: clearing an already-clear bit still writes
        rf[1] = 0; mem_b[8'h44] = 8'hFE;
        run(16'h0180 | (16'd1 << 9) | (16'd7 << 3) | 16'd1, 24'h000044, 16'h0, 1);
        // R9: rejected opcodes
        bad(16'h0108);
        bad(16'h0000);
        bad(16'h083C);
        // R1: legal form still works after rejections
        rf[1] = 0; rf[2] = 32'h1;
        run(16'h0100 | (16'd1 << 9) | 16'd2, 24'h0, 16'h0, 0);

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule